// File: doc/BRIEF.md
# Coherent Sample Register Bank

This block is the read-only register file behind a serial-bus target in a three-axis motion sensor. On each new-sample strobe it stores a signed 14-bit sample for each of three axes. It raises one ready flag per axis and one flag that covers all axes. Reads from the bus side return one byte per access. Each sample is exposed as a high byte and a low byte.

Reading a high byte lowers that axis's flag. The same read copies the sample's low bits into a shadow byte. The low byte is only delivered on the next read access, and it comes from that shadow. A pair read high-then-low therefore always comes from a single sample, even when a new sample arrives between the two accesses. A bus STOP, any other access, or pulling the enable input low breaks that pairing. Pulling enable low also clears the whole bank.

Top module: `sample_regbank`

## Requirements
- R1: The status byte is at address 0x00: bit 0 is X ready, bit 1 is Y ready, bit 2 is Z ready, bit 3 is all-axes ready, and bits 7:4 read 0. After reset every readable byte is 0x00.
- R2: A new-sample strobe with enable high stores all three samples and sets all three per-axis ready bits and the all-axes ready bit.
- R3: Reading an axis's high byte (X 0x01, Y 0x03, Z 0x05) clears that axis's ready bit and no other per-axis bit.
- R4: The all-axes ready bit stays set until all three high bytes have been read since the last sample, and clears on the third of those reads.
- R5: A high byte returns sample bits [13:6]. The low byte (X 0x02, Y 0x04, Z 0x06) returns sample bits [5:0] in bit positions [7:2], with bits [1:0] zero.
- R6: A low-byte read returns the value captured at the preceding high-byte read of that axis, even if a new sample has been stored in between.
- R7: A low-byte read that is not the very next read after its own high byte returns 0x00 and changes no flag. A bus STOP between the two reads also counts as breaking the pair; idle cycles do not.
- R8: When a new-sample strobe and a high-byte read of an axis fall in the same cycle, the read returns the old sample and the ready bit ends up set.
- R9: While enable is low, all stored samples, flags, shadows and read data are cleared to zero.
- R10: Read data is updated on the clock edge that samples a read strobe and holds otherwise. A read of any address above 0x06 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Sensor enable; low clears the bank |
| smp_valid | input | 1 | New-sample strobe, one cycle |
| smp_x | input | 14 | X sample, two's complement |
| smp_y | input | 14 | Y sample, two's complement |
| smp_z | input | 14 | Z sample, two's complement |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| rd_addr | input | 8 | Register address of the read |
| bus_stop | input | 1 | Bus STOP seen; breaks any high/low pairing |
| rd_data | output | 8 | Byte returned by the last read |

## Verification
The assertions check the flag rules on every cycle: a strobe leaves the flag set, a high-byte read with no strobe leaves it clear, and the all-axes flag always agrees with the per-axis flags. They also check that the shadow byte only moves on a high-byte read, that read data holds between strobes, and that enable low empties the bank. The bench scenarios are what show byte coherence across an intervening sample, the denial of a low byte after a STOP or after another access, the exact bit packing, and the set-over-clear collision. Each of these depends on a sequence of reads and is compared against values the bench works out from the sample words.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // Kind of register an address selects
    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_STATUS = 2'd1,
        ACC_MSB    = 2'd2,
        ACC_LSB    = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/sreg_axis_slot.sv
module sreg_axis_slot
    import sreg_pkg::*;
#(
    parameter int SMP_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             load,
    input  logic [SMP_W-1:0] sample,
    input  logic             msb_rd,
    output byte_t            msb_byte,
    output byte_t            lsb_shadow,
    output logic             rdy
);

    localparam int LSB_BITS = SMP_W - BYTE_W;
    localparam int PAD_BITS = BYTE_W - LSB_BITS;

    typedef struct packed {
        logic [SMP_W-1:0] smp;
        byte_t            shadow;
        logic             rdy;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (!enable) begin
            slot_d = '0;
        end else begin
            if (msb_rd) begin
                slot_d.shadow = {slot_q.smp[LSB_BITS-1:0], {PAD_BITS{1'b0}}};
                slot_d.rdy    = 1'b0;
            end
            if (load) begin
                slot_d.smp = sample;
                slot_d.rdy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign msb_byte   = slot_q.smp[SMP_W-1 -: BYTE_W];
    assign lsb_shadow = slot_q.shadow;
    assign rdy        = slot_q.rdy;

    // R2
    load_sets_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable && load |=> rdy);

    // R3
    msb_rd_clears_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable && msb_rd && !load |=> !rdy);

    // R6
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable && !msb_rd |=> $stable(lsb_shadow));

    // R9
    disable_clears_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!rdy && msb_byte == '0 && lsb_shadow == '0));

endmodule

// File: rtl/sreg_read_ctrl.sv
module sreg_read_ctrl
    import sreg_pkg::*;
#(
    parameter int NUM_AXES = 3,
    parameter int ADDR_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic                       bus_stop,
    input  byte_t                      status_byte,
    input  byte_t [NUM_AXES-1:0]       msb_bytes,
    input  byte_t [NUM_AXES-1:0]       lsb_shadows,
    output logic  [NUM_AXES-1:0]       msb_rd,
    output byte_t                      rd_data
);

    localparam int AXW      = (NUM_AXES > 1) ? $clog2(NUM_AXES) : 1;
    localparam int LAST_REG = 2 * NUM_AXES;

    typedef struct packed {
        logic           arm_vld;
        logic [AXW-1:0] arm_axis;
        byte_t          data;
    } rctl_t;

    rctl_t          rctl_d, rctl_q;
    acc_kind_e      kind;
    logic [ADDR_W-1:0] off;
    logic [AXW-1:0] axis_sel;
    byte_t          sel_byte;

    // Address decode: 0 is status, then high/low pairs per axis
    always_comb begin
        off      = rd_addr - 1'b1;
        axis_sel = off[AXW:1];
        if (rd_addr == '0)
            kind = ACC_STATUS;
        else if (rd_addr <= ADDR_W'(LAST_REG))
            kind = off[0] ? ACC_LSB : ACC_MSB;
        else
            kind = ACC_NONE;
    end

    always_comb begin
        sel_byte = '0;
        unique case (kind)
            ACC_STATUS: sel_byte = status_byte;
            ACC_MSB:    sel_byte = msb_bytes[axis_sel];
            ACC_LSB:    sel_byte = (rctl_q.arm_vld && rctl_q.arm_axis == axis_sel)
                                   ? lsb_shadows[axis_sel] : '0;
            default:    sel_byte = '0;
        endcase
    end

    always_comb begin
        msb_rd = '0;
        if (enable && rd_en && kind == ACC_MSB)
            msb_rd[axis_sel] = 1'b1;
    end

    always_comb begin
        rctl_d = rctl_q;
        if (!enable) begin
            rctl_d = '0;
        end else begin
            if (rd_en) begin
                rctl_d.data     = sel_byte;
                rctl_d.arm_vld  = (kind == ACC_MSB);
                rctl_d.arm_axis = axis_sel;
            end
            if (bus_stop)
                rctl_d.arm_vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rctl_q <= '0;
        else        rctl_q <= rctl_d;
    end

    assign rd_data = rctl_q.data;

    // R10
    rd_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable && !rd_en |=> $stable(rd_data));

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_addr > ADDR_W'(LAST_REG) |=> rd_data == '0);

    // R7
    stop_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !rctl_q.arm_vld);

    // R3
    msb_rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(msb_rd));

endmodule

// File: rtl/sample_regbank.sv
module sample_regbank
    import sreg_pkg::*;
#(
    parameter int NUM_AXES = 3,
    parameter int SMP_W    = 14,
    parameter int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_x,
    input  logic [SMP_W-1:0]  smp_y,
    input  logic [SMP_W-1:0]  smp_z,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              bus_stop,
    output logic [7:0]        rd_data
);

    localparam int STAT_PAD = BYTE_W - NUM_AXES - 1;

    typedef struct packed {
        logic                all_rdy;
        logic [NUM_AXES-1:0] seen;
    } agg_t;

    logic [NUM_AXES-1:0][SMP_W-1:0] samples;
    byte_t [NUM_AXES-1:0]           msb_bytes;
    byte_t [NUM_AXES-1:0]           lsb_shadows;
    logic  [NUM_AXES-1:0]           axis_rdy;
    logic  [NUM_AXES-1:0]           msb_rd;
    byte_t                          status_byte;
    byte_t                          rdata;
    agg_t                           agg_d, agg_q;

    assign samples = {smp_z, smp_y, smp_x};

    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        sreg_axis_slot #(.SMP_W(SMP_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .enable     (enable),
            .load       (smp_valid),
            .sample     (samples[a]),
            .msb_rd     (msb_rd[a]),
            .msb_byte   (msb_bytes[a]),
            .lsb_shadow (lsb_shadows[a]),
            .rdy        (axis_rdy[a])
        );
    end

    // All-axes flag: cleared once every high byte has been read
    always_comb begin
        agg_d = agg_q;
        if (!enable) begin
            agg_d = '0;
        end else if (smp_valid) begin
            agg_d.all_rdy = 1'b1;
            agg_d.seen    = '0;
        end else begin
            agg_d.seen = agg_q.seen | msb_rd;
            if (&agg_d.seen) begin
                agg_d.all_rdy = 1'b0;
                agg_d.seen    = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) agg_q <= '0;
        else        agg_q <= agg_d;
    end

    assign status_byte = {{STAT_PAD{1'b0}}, agg_q.all_rdy, axis_rdy};

    sreg_read_ctrl #(.NUM_AXES(NUM_AXES), .ADDR_W(ADDR_W)) u_rctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .bus_stop    (bus_stop),
        .status_byte (status_byte),
        .msb_bytes   (msb_bytes),
        .lsb_shadows (lsb_shadows),
        .msb_rd      (msb_rd),
        .rd_data     (rdata)
    );

    assign rd_data = rdata;

    // R4
    all_rdy_agrees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        agg_q.all_rdy == (|axis_rdy));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable && smp_valid && (|msb_rd) |=> (&axis_rdy) && agg_q.all_rdy);

    // R9
    disable_clears_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!agg_q.all_rdy && rd_data == '0));

endmodule

// File: tb/tb_sample_regbank.sv
module tb_sample_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        smp_valid = 1'b0;
    logic [13:0] smp_x = '0, smp_y = '0, smp_z = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic        bus_stop = 1'b0;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sample_regbank dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .smp_valid(smp_valid),
        .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z), .rd_en(rd_en),
        .rd_addr(rd_addr), .bus_stop(bus_stop), .rd_data(rd_data)
    );

    function automatic logic [7:0] hi_of(logic [13:0] v);
        return v[13:6];
    endfunction

    function automatic logic [7:0] lo_of(logic [13:0] v);
        return {v[5:0], 2'b00};
    endfunction

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        rd_en = 1'b1; rd_addr = a;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic push(logic [13:0] x, logic [13:0] y, logic [13:0] z);
        smp_valid = 1'b1; smp_x = x; smp_y = y; smp_z = z;
        @(posedge clk); @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic stop_pulse();
        bus_stop = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_stop = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 0; a <= 6; a++) begin
            rd(8'(a), d);
            chk("R1 reset value", d, 8'h00);
        end
    endtask

    task automatic t_basic();
        logic [7:0] d;
        push(14'h2ABC, 14'h1555, 14'h3FFF);
        rd(8'h00, d); chk("R2 status after sample", d, 8'h0F);
        rd(8'h01, d); chk("R5 X high byte", d, hi_of(14'h2ABC));
        rd(8'h02, d); chk("R5 X low byte", d, lo_of(14'h2ABC));
        rd(8'h00, d); chk("R3 X flag cleared only", d, 8'h0E);
        rd(8'h05, d); chk("R5 Z high byte", d, hi_of(14'h3FFF));
        rd(8'h06, d); chk("R5 Z low byte", d, lo_of(14'h3FFF));
        rd(8'h03, d); chk("R5 Y high byte", d, hi_of(14'h1555));
        repeat (3) @(negedge clk);
        chk("R7 idle cycles keep pairing / R10 hold", rd_data, hi_of(14'h1555));
        rd(8'h04, d); chk("R7 Y low byte after idle", d, lo_of(14'h1555));
        rd(8'h00, d); chk("R4 all flags clear", d, 8'h00);
    endtask

    task automatic t_coherent();
        logic [7:0] d;
        push(14'h0123, 14'h2D47, 14'h0F0F);
        rd(8'h03, d); chk("R5 Y high first sample", d, hi_of(14'h2D47));
        push(14'h3210, 14'h1B39, 14'h00F0);
        rd(8'h04, d); chk("R6 Y low from shadow", d, lo_of(14'h2D47));
        rd(8'h00, d); chk("R2 flags set by new sample", d, 8'h0F);
        rd(8'h03, d); chk("R6 Y high new sample", d, hi_of(14'h1B39));
        rd(8'h04, d); chk("R6 Y low new sample", d, lo_of(14'h1B39));
    endtask

    task automatic t_random_lsb();
        logic [7:0] d;
        push(14'h1F3D, 14'h2222, 14'h3A5B);
        rd(8'h01, d); chk("R5 X high", d, hi_of(14'h1F3D));
        stop_pulse();
        rd(8'h02, d); chk("R7 X low after STOP", d, 8'h00);
        rd(8'h03, d); chk("R5 Y high", d, hi_of(14'h2222));
        rd(8'h00, d); chk("R3 status after X,Y", d, 8'h0C);
        rd(8'h04, d); chk("R7 Y low after other read", d, 8'h00);
        rd(8'h06, d); chk("R7 Z low without high", d, 8'h00);
        rd(8'h00, d); chk("R7 flags untouched", d, 8'h0C);
        rd(8'h05, d); chk("R5 Z high", d, hi_of(14'h3A5B));
        rd(8'h02, d); chk("R7 X low after Z high", d, 8'h00);
    endtask

    task automatic t_all_clear();
        logic [7:0] d;
        push(14'h0001, 14'h2000, 14'h1FFF);
        rd(8'h05, d); chk("R5 Z high boundary", d, hi_of(14'h1FFF));
        rd(8'h00, d); chk("R4 all kept after one", d, 8'h0B);
        rd(8'h01, d); chk("R5 X high small", d, hi_of(14'h0001));
        rd(8'h02, d); chk("R5 X low small", d, lo_of(14'h0001));
        rd(8'h00, d); chk("R4 all kept after two", d, 8'h0A);
        rd(8'h03, d); chk("R5 Y high most negative", d, hi_of(14'h2000));
        rd(8'h00, d); chk("R4 all cleared after three", d, 8'h00);
    endtask

    task automatic t_set_wins();
        logic [7:0] d;
        push(14'h1234, 14'h0AAA, 14'h0555);
        rd(8'h00, d);
        rd_en = 1'b1; rd_addr = 8'h01;
        smp_valid = 1'b1; smp_x = 14'h3ACE; smp_y = 14'h0BBB; smp_z = 14'h0666;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0; smp_valid = 1'b0;
        chk("R8 read returns old sample", rd_data, hi_of(14'h1234));
        rd(8'h00, d); chk("R8 set wins over clear", d, 8'h0F);
        rd(8'h01, d); chk("R8 new sample stored", d, hi_of(14'h3ACE));
        rd(8'h02, d); chk("R6 low of new sample", d, lo_of(14'h3ACE));
    endtask

    task automatic t_enable_low();
        logic [7:0] d;
        push(14'h2F00, 14'h1E00, 14'h0D00);
        rd(8'h03, d);
        enable = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R9 read data cleared", rd_data, 8'h00);
        enable = 1'b1;
        rd(8'h00, d); chk("R9 status cleared", d, 8'h00);
        rd(8'h01, d); chk("R9 X cleared", d, 8'h00);
        rd(8'h03, d); chk("R9 Y cleared", d, 8'h00);
        rd(8'h04, d); chk("R9 Y shadow cleared", d, 8'h00);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        push(14'h3FC0, 14'h0040, 14'h0001);
        rd(8'h07, d); chk("R10 address 0x07", d, 8'h00);
        rd(8'hFF, d); chk("R10 address 0xFF", d, 8'h00);
        rd(8'h00, d); chk("R1 upper status bits zero", d & 8'hF0, 8'h00);
        rd(8'h01, d); chk("R10 read after unmapped", d, hi_of(14'h3FC0));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        enable = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_coherent();
        t_random_lsb();
        t_all_clear();
        t_set_wins();
        t_enable_low();
        t_unmapped();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule